// File: doc/BRIEF.md
# Zero-Gated Cache Line Store

This block holds the data lines of a cache and splits each line into equal groups of bits. On every write it notes, group by group, whether the incoming group is entirely zero. It keeps that one-bit note per group in a small flag store next to the data. A group marked as zero is not written into its storage bank. On a later read the bank is not enabled at all: the block drives zeros for that group instead of sensing the cells. Only groups that hold some set bit cost an array access.

Each port reports how many group banks it enabled in that access. A write reports the count in the same cycle. A read reports it alongside the read data one cycle later. A surrounding design or a bench can use this count as a measure of array activity. Line width, group width and line count are parameters, so the same wrapper serves word, half-word, byte or half-byte grouping.

Top module: `zero_gated_line_store`

## Requirements
- R1: Group g of a line is bits [g*GRP_W +: GRP_W]. While `wr_en` is high, `wr_grp_active` equals the number of groups of `wr_data` that have at least one bit set. While `wr_en` is low it is 0. Only those groups are written.
- R2: A read requested with `rd_en` high at a rising edge presents `rd_valid` high, `rd_data` and `rd_grp_active` after that edge. `rd_valid` is low after any edge without a read request.
- R3: A read returns, for every group, the value most recently written to that line. This includes a zero group written over an earlier nonzero value.
- R4: `rd_grp_active` equals the number of groups whose most recent written value is nonzero. It is 0 whenever `rd_valid` is low.
- R5: After reset, `rd_valid`, `rd_data` and both counts are 0. Every line reads as all zeros with a count of 0 until it is written.
- R6: When a read and a write address the same line in the same cycle, the read returns the line's content from before that write.
- R7: While no read is requested, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | $clog2(DEPTH) | Line written |
| wr_data | input | LINE_W | Line value to store |
| rd_en | input | 1 | Read request |
| rd_idx | input | $clog2(DEPTH) | Line read |
| rd_data | output | LINE_W | Read result, one cycle after the request |
| rd_valid | output | 1 | High for the cycle that carries a read result |
| wr_grp_active | output | $clog2(LINE_W/GRP_W+1) | Group banks enabled by the current write |
| rd_grp_active | output | $clog2(LINE_W/GRP_W+1) | Group banks enabled by the read that produced `rd_data` |

## Verification
The bench builds the block with a 32-bit line, 4-bit (half-byte) groups and four lines. Every group boundary and every group count from 0 to 8 can then be reached with hand-written line values. The small depth lets the test overwrite every line several times. Overwriting nonzero groups with zeros shows that stale cells in a skipped bank never leak into a read. A read and a write colliding on one line show the ordering rule.

// File: rtl/zgl_pkg.sv
// Shared helpers for the zero-gated line store.
// Assumes no configuration has more than MAX_GRP groups per line.
package zgl_pkg;
    localparam int MAX_GRP = 64;

    // Count set bits of a group-flag vector (zero-extended to MAX_GRP bits).
    function automatic logic [6:0] ones64(input logic [MAX_GRP-1:0] v);
        logic [6:0] n;
        n = '0;
        for (int i = 0; i < MAX_GRP; i++) begin
            n = n + {6'd0, v[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/zgl_zero_detect.sv
// Flags every all-zero group of a line.
// Assumes LINE_W is a whole multiple of GRP_W; purely combinational.
module zgl_zero_detect #(
    parameter int LINE_W = 128,
    parameter int GRP_W  = 8,
    localparam int NGRP  = LINE_W / GRP_W
) (
    input  logic [LINE_W-1:0] line,
    output logic [NGRP-1:0]   is_zero
);
    for (genvar g = 0; g < NGRP; g++) begin : g_det
        // NOR-reduce one group
        assign is_zero[g] = ~|line[g*GRP_W +: GRP_W];
    end
endmodule

// File: rtl/zgl_group_bank.sv
// Storage for one group position across all lines, with separate write and
// read enables. The read register only updates when the read is enabled.
// Assumes the cell contents need no reset; only the output register is reset.
module zgl_group_bank #(
    parameter int GRP_W = 8,
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [GRP_W-1:0] wd,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [GRP_W-1:0] rq
);
    logic [GRP_W-1:0] cells [DEPTH];

    // Store the group when this bank is write-enabled
    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wd;
        end
    end

    // Sense the addressed cells only when this bank is read-enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq <= '0;
        end else if (re) begin
            rq <= cells[ridx];
        end
    end
endmodule

// File: rtl/zero_gated_line_store.sv
// Cache line store with one zero flag per group. All-zero groups skip both
// write and read of their bank; reads substitute zeros for them. Reports the
// number of banks enabled per access. Assumes LINE_W % GRP_W == 0 and
// LINE_W / GRP_W <= 64. Read latency is one cycle; a read colliding with a
// write to the same line sees the old content.
module zero_gated_line_store #(
    parameter int LINE_W = 128,
    parameter int GRP_W  = 8,
    parameter int DEPTH  = 16,
    localparam int NGRP  = LINE_W / GRP_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(NGRP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  wr_grp_active,
    output logic [CNT_W-1:0]  rd_grp_active
);
    logic [NGRP-1:0] wr_zero;
    logic [NGRP-1:0] wr_use;
    logic [NGRP-1:0] rd_zero_now;
    logic [NGRP-1:0] rd_use;
    logic [NGRP-1:0] rd_zero_q;
    logic [NGRP-1:0] zflag [DEPTH];
    logic [GRP_W-1:0] bank_q [NGRP];
    logic [CNT_W-1:0] rd_cnt_next;

    zgl_zero_detect #(.LINE_W(LINE_W), .GRP_W(GRP_W)) u_detect (
        .line    (wr_data),
        .is_zero (wr_zero)
    );

    assign rd_zero_now = zflag[rd_idx];
    assign wr_use      = ~wr_zero;
    assign rd_use      = ~rd_zero_now;

    // Zero flags per line; reset marks every group of every line as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                zflag[i] <= '1;
            end
        end else if (wr_en) begin
            zflag[wr_idx] <= wr_zero;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        zgl_group_bank #(.GRP_W(GRP_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & wr_use[g]),
            .widx  (wr_idx),
            .wd    (wr_data[g*GRP_W +: GRP_W]),
            .re    (rd_en & rd_use[g]),
            .ridx  (rd_idx),
            .rq    (bank_q[g])
        );
        // Force zeros for groups flagged at read time
        assign rd_data[g*GRP_W +: GRP_W] = rd_zero_q[g] ? '0 : bank_q[g];
    end

    // Enabled-bank count of the current write
    always_comb begin
        wr_grp_active = '0;
        if (wr_en) begin
            wr_grp_active = CNT_W'(zgl_pkg::ones64(zgl_pkg::MAX_GRP'(wr_use)));
        end
    end

    // Enabled-bank count of the current read, before registering
    always_comb begin
        rd_cnt_next = CNT_W'(zgl_pkg::ones64(zgl_pkg::MAX_GRP'(rd_use)));
    end

    // Read-side registers: gating flags, valid and count travel with the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_zero_q     <= '1;
            rd_valid      <= 1'b0;
            rd_grp_active <= '0;
        end else begin
            rd_valid      <= rd_en;
            rd_grp_active <= rd_en ? rd_cnt_next : '0;
            if (rd_en) begin
                rd_zero_q <= rd_zero_now;
            end
        end
    end
endmodule

// File: rtl/zgl_line_store_chk.sv
// Protocol checks on the ports of zero_gated_line_store, bound to every
// instance. Assumes the same parameters as the checked instance.
module zgl_line_store_chk #(
    parameter int LINE_W = 128,
    parameter int GRP_W  = 8,
    parameter int DEPTH  = 16,
    localparam int NGRP  = LINE_W / GRP_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(NGRP + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [LINE_W-1:0] wr_data,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [LINE_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  wr_grp_active,
    input logic [CNT_W-1:0]  rd_grp_active
);
    int rd_nz_groups;

    // Count groups of the read data that carry a set bit
    always_comb begin
        rd_nz_groups = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (|rd_data[g*GRP_W +: GRP_W]) begin
                rd_nz_groups++;
            end
        end
    end

    // R1
    wr_idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> wr_grp_active == '0);

    // R1
    wr_zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |-> wr_grp_active == '0);

    // R2
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R4
    rd_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_grp_active == '0);

    // R4
    rd_count_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_nz_groups <= int'(rd_grp_active));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind zero_gated_line_store zgl_line_store_chk #(
    .LINE_W (LINE_W),
    .GRP_W  (GRP_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .rd_en         (rd_en),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .wr_grp_active (wr_grp_active),
    .rd_grp_active (rd_grp_active)
);

// File: tb/zero_gated_line_store_tb.sv
module zero_gated_line_store_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 32;
    localparam int GRP_W  = 4;
    localparam int DEPTH  = 4;
    localparam int NGRP   = LINE_W / GRP_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(NGRP + 1);
    localparam int NVEC   = 8;

    // Each entry: {line index, line value}; read back must equal the value
    localparam logic [IDX_W+LINE_W-1:0] VEC [NVEC] = '{
        {2'd0, 32'h12345678},
        {2'd1, 32'h00000000},
        {2'd2, 32'hF000000F},
        {2'd3, 32'h0A0B0C0D},
        {2'd0, 32'h00000001},
        {2'd1, 32'h80000000},
        {2'd2, 32'h00FF0000},
        {2'd3, 32'hFFFFFFFF}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [LINE_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [LINE_W-1:0] rd_data;
    logic              rd_valid;
    logic [CNT_W-1:0]  wr_grp_active;
    logic [CNT_W-1:0]  rd_grp_active;

    int n_checks = 0;
    int n_fails  = 0;

    zero_gated_line_store #(.LINE_W(LINE_W), .GRP_W(GRP_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_grp_active(wr_grp_active), .rd_grp_active(rd_grp_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int nz_groups(input logic [LINE_W-1:0] v);
        int n = 0;
        for (int g = 0; g < NGRP; g++) begin
            if (v[g*GRP_W +: GRP_W] != '0) n++;
        end
        return n;
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Write one line; checks the same-cycle enabled-bank count (R1)
    task automatic do_write(input logic [IDX_W-1:0] idx, input logic [LINE_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        #1;
        check("R1", "write bank count", wr_grp_active, nz_groups(d));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one line; checks data (R3), count (R4) and valid (R2)
    task automatic do_read(input logic [IDX_W-1:0] idx, input logic [LINE_W-1:0] exp_d,
                           input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        check("R2", "read valid", rd_valid, 1);
        check(req, "read data", rd_data, exp_d);
        check("R4", "read bank count", rd_grp_active, nz_groups(exp_d));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5", "rd_valid in reset", rd_valid, 0);
        check("R5", "rd_data in reset", rd_data, 0);
        check("R5", "rd count in reset", rd_grp_active, 0);
        check("R5", "wr count in reset", wr_grp_active, 0);
        rst_n = 1'b1;
        // R5: unwritten line reads as zero with no banks enabled
        do_read(2'd3, 32'h0, "R5");

        // Table walk: R1, R2, R3, R4
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][IDX_W+LINE_W-1:LINE_W], VEC[v][LINE_W-1:0]);
            do_read(VEC[v][IDX_W+LINE_W-1:LINE_W], VEC[v][LINE_W-1:0], "R3");
        end

        // R2: valid drops after a cycle without a read
        @(negedge clk);
        check("R2", "valid after idle", rd_valid, 0);

        // R3: zero groups over stale nonzero cells read as zero
        do_write(2'd3, 32'h00F0000F);
        do_read(2'd3, 32'h00F0000F, "R3");

        // R1/R3: all-zero line enables nothing and reads zero
        do_write(2'd0, 32'h0);
        do_read(2'd0, 32'h0, "R3");

        // R6: collision returns the old content, then the new
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd2; wr_data = 32'h11111111;
        rd_en = 1'b1; rd_idx = 2'd2;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R6", "collision data", rd_data, 32'h00FF0000);
        check("R6", "collision count", rd_grp_active, 2);
        do_read(2'd2, 32'h11111111, "R6");

        // R7: data held over idle cycles; R4 count drops to 0
        repeat (3) @(negedge clk);
        check("R7", "held data", rd_data, 32'h11111111);
        check("R4", "idle read count", rd_grp_active, 0);

        finish_run();
    end
endmodule